// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire serial bus read and write a small file of byte-wide configuration registers. Both bus lines are sampled on the system clock, and each must hold steady for three samples before the block accepts a change. From the cleaned lines it detects START, repeated START and STOP conditions, takes bytes in on the rising clock edge and changes its own data line after the falling edge. It only ever pulls the data line low, through an output enable.

A transaction opens with a 7-bit device address, which the block compares with seven strap inputs. The block acknowledges a match and ignores everything else until the next START. In a write, the first byte loads an 8-bit register pointer. Each byte after it is stored at the pointer, and the pointer then steps up by one. A read starts at the current pointer and steps the pointer after every byte. The pointer is kept across a repeated START, so the usual read is a write of the pointer, a repeated START, then the address with the read bit set.

Register 0 is a read-only identity byte. Register 2 holds two control bits. Bit 4 starts a full register reset and clears itself when the reset ends. Bit 5 requests power-down; it is ORed with an external pin to form the power-down output. The serial link keeps working while power-down is active.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `dev_addr` (the lowest bit is the read/write flag, 1 = read). On a mismatch it acknowledges nothing and writes nothing until the next START.
- R2: In a write, the first byte after the address sets the pointer. Each following byte is stored at the pointer, and the pointer then increments.
- R3: A read returns the register at the pointer and increments the pointer after each byte. When the master acknowledges, the next byte follows. When the master does not acknowledge, the burst ends and the data line stays released.
- R4: The pointer survives a repeated START and a STOP. A read that is not preceded by a pointer write continues from where the last access left it.
- R5: The clock and data inputs are filtered so that any pulse shorter than three system-clock samples is ignored. Such a pulse neither shifts a bit nor forms a START or STOP.
- R6: The output enable `sda_oe` changes only while the filtered clock is low.
- R7: Register 0x00 reads `{DEV_ID, DEV_REV}` (0x31 by default). A write to it is acknowledged and has no effect.
- R8: Writing 1 to bit 4 of register 0x02 raises `soft_rst` for exactly RST_CYCLES clocks (16 by default). All registers then return to their reset values, which clears bit 4.
- R9: `pd_out` is high when `pd_pin` is high or bit 5 of register 0x02 is set. Reads and writes keep working while `pd_out` is high.
- R10: Pointer values of NREGS (16) or above read as 0x00, and writes to them are discarded.
- R11: After reset, `sda_oe` and `soft_rst` are low and every register other than 0x00 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| dev_addr | input | 7 | Strapped 7-bit device address |
| pd_pin | input | 1 | External power-down request |
| pd_out | output | 1 | Combined power-down output |
| soft_rst | output | 1 | High while a register-requested reset runs |

## Verification
A table of pointer and data pairs is walked as single-byte writes, each followed by a pointer write, a repeated START and a read. A mismatch here separates storage and pointer loading from faults in the address path. Multi-byte bursts with master ACK and then NACK show whether the pointer increments between bytes and whether the slave releases the line at the end. A read that follows without a pointer write shows that the pointer is kept. A wrong device address, writes to the identity register and to out-of-range pointers, and short pulses on both lines must all leave the stored values unchanged. The power-down pin, the power-down bit and the self-clearing reset bit are each checked at the output ports, by counting the cycles the reset output stays high.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;

    // Control register location and bit positions
    localparam logic [PTR_W-1:0] CTRL_ADDR = 8'h02;
    localparam int               RST_BIT   = 4;
    localparam int               PD_BIT    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TX_ACK
    } link_state_t;

    typedef struct packed {
        logic              stb;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] reset_value(input int idx,
                                                      input logic [3:0] id,
                                                      input logic [3:0] rev);
        return (idx == 0) ? {id, rev} : '0;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
            dout <= 1'b1;
        end else begin
            hist <= {hist[STAGES-2:0], din};
            if (&hist)
                dout <= 1'b1;
            else if (~|hist)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_link_engine.sv
module i2c_link_engine
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output reg_wr_t           wr_bus,
    output logic              sda_oe
);
    link_state_t       state;
    logic              scl_d, sda_d;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              rw_q, ptr_phase, nack_q;

    logic start_c, stop_c, rise_c, fall_c;
    logic [BYTE_W-1:0] byte_in;

    always_comb begin
        start_c = scl_f && scl_d && sda_d && !sda_f;
        stop_c  = scl_f && scl_d && !sda_d && sda_f;
        rise_c  = scl_f && !scl_d;
        fall_c  = !scl_f && scl_d;
        byte_in = {rx_sh[BYTE_W-2:0], sda_f};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_q      <= 1'b0;
            ptr_phase <= 1'b0;
            nack_q    <= 1'b0;
            ptr       <= '0;
            wr_bus    <= '0;
            sda_oe    <= 1'b0;
        end else begin
            scl_d      <= scl_f;
            sda_d      <= sda_f;
            wr_bus.stb <= 1'b0;
            if (start_c) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: if (rise_c) begin
                        rx_sh   <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (rx_sh[6:0] == dev_addr) begin
                                rw_q      <= sda_f;
                                ptr_phase <= 1'b1;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (fall_c) begin
                        if (!sda_oe) begin
                            sda_oe <= 1'b1;
                        end else if (rw_q) begin
                            state   <= ST_TX;
                            tx_sh   <= rd_data;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            bit_cnt <= '0;
                        end else begin
                            state   <= ST_RX;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RX: if (rise_c) begin
                        rx_sh   <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state <= ST_ACK;
                            if (ptr_phase) begin
                                ptr       <= byte_in;
                                ptr_phase <= 1'b0;
                            end else begin
                                wr_bus.stb  <= 1'b1;
                                wr_bus.addr <= ptr;
                                wr_bus.data <= byte_in;
                                ptr         <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_TX: if (fall_c) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                            ptr    <= ptr + 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (rise_c)
                            nack_q <= sda_f;
                        if (fall_c) begin
                            if (nack_q) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_TX;
                                tx_sh   <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= '0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int         NREGS      = 16,
    parameter int         RST_CYCLES = 16,
    parameter logic [3:0] DEV_ID     = 4'h3,
    parameter logic [3:0] DEV_REV    = 4'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr_bus,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pd_reg,
    output logic              soft_rst
);
    localparam int IDX_W = $clog2(NREGS);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NREGS);
    localparam logic [IDX_W-1:0] CTRL_IDX = CTRL_ADDR[IDX_W-1:0];

    logic [BYTE_W-1:0] regs [NREGS];
    logic [CNT_W-1:0]  cnt;
    logic              wr_ok, rd_ok;

    always_comb begin
        wr_ok    = wr_bus.stb && ({1'b0, wr_bus.addr} < LIMIT) && (wr_bus.addr != '0);
        rd_ok    = {1'b0, rd_addr} < LIMIT;
        rd_data  = rd_ok ? regs[rd_addr[IDX_W-1:0]] : '0;
        soft_rst = regs[CTRL_IDX][RST_BIT];
        pd_reg   = regs[CTRL_IDX][PD_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || (soft_rst && cnt == CNT_W'(RST_CYCLES - 1))) begin
            for (int i = 0; i < NREGS; i++)
                regs[i] <= reset_value(i, DEV_ID, DEV_REV);
            cnt <= '0;
        end else begin
            if (soft_rst)
                cnt <= cnt + 1'b1;
            if (wr_ok)
                regs[wr_bus.addr[IDX_W-1:0]] <= wr_bus.data;
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int         NREGS        = 16,
    parameter int         RST_CYCLES   = 16,
    parameter int         FILT_SAMPLES = 3,
    parameter logic [3:0] DEV_ID       = 4'h3,
    parameter logic [3:0] DEV_REV      = 4'h1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [6:0] dev_addr,
    input  logic       pd_pin,
    output logic       pd_out,
    output logic       soft_rst
);
    logic              scl_f, sda_f, pd_reg;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    reg_wr_t           wr_bus;

    i2c_glitch_filter #(.STAGES(FILT_SAMPLES)) u_scl_filt (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));

    i2c_glitch_filter #(.STAGES(FILT_SAMPLES)) u_sda_filt (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));

    i2c_link_engine u_link (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
        .dev_addr(dev_addr), .rd_data(rd_data), .ptr(ptr),
        .wr_bus(wr_bus), .sda_oe(sda_oe));

    cfg_reg_bank #(
        .NREGS(NREGS), .RST_CYCLES(RST_CYCLES),
        .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_bus(wr_bus), .rd_addr(ptr),
        .rd_data(rd_data), .pd_reg(pd_reg), .soft_rst(soft_rst));

    assign pd_out = pd_reg | pd_pin;
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic sda_oe,
    input logic pd_pin,
    input logic pd_out,
    input logic soft_rst,
    input logic wr_stb
);
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= 0;
        else if (soft_rst)
            hi_cnt <= hi_cnt + 1;
        else
            hi_cnt <= 0;
    end

    assert_oe_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    assert_pin_forces_pd_R9: assert property (@(posedge clk) disable iff (rst)
        pd_pin |-> pd_out);

    assert_reset_length_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(soft_rst) |-> (hi_cnt == RST_CYCLES));

    assert_write_on_high_clk_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> scl_f);

    assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !soft_rst));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_oe(sda_oe), .pd_pin(pd_pin),
    .pd_out(pd_out), .soft_rst(soft_rst), .wr_stb(wr_bus.stb));

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
    localparam int         Q   = 10;
    localparam logic [6:0] DEV = 7'h5A;
    localparam int         NV  = 6;
    localparam logic [15:0] VEC [NV] = '{16'h01A5, 16'h035A, 16'h04FF,
                                         16'h0F3C, 16'h0700, 16'h0981};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, pd_pin = 1'b0;
    logic sda_oe, pd_out, soft_rst, sda_line;
    int   n_cmp = 0, n_bad = 0, rst_hi = 0, oe_viol = 0;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_addr(DEV), .pd_pin(pd_pin), .pd_out(pd_out), .soft_rst(soft_rst));

    always @(negedge clk) begin
        if (soft_rst) rst_hi++;
        if (sda_oe != oe_prev && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b, input logic g);
        sda_m = b; wt(Q);
        if (g) begin scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(Q); end
        scl_m = 1'b1; wt(Q);
        if (g) begin sda_m = ~b; wt(2); sda_m = b; end
        wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic g, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i], g);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nack, 1'b0);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input logic g, input string req);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b0}, g, ack); chk(req, {7'd0, ack}, 8'd1);
        wr_byte(a, g, ack);
        wr_byte(d, g, ack);           chk(req, {7'd0, ack}, 8'd1);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(a, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin : main
        logic [7:0] d;
        logic ack;
        wt(5); rst = 1'b0; wt(3);

        // R11: reset state at the ports
        chk("R11 sda_oe", {7'd0, sda_oe}, 8'd0);
        chk("R11 soft_rst", {7'd0, soft_rst}, 8'd0);
        chk("R11 pd_out", {7'd0, pd_out}, 8'd0);
        rd_reg(8'h05, d); chk("R11 reg05", d, 8'h00);

        // R7: identity register, write ignored
        rd_reg(8'h00, d); chk("R7 id", d, 8'h31);
        wr_reg(8'h00, 8'hFF, 1'b0, "R7 ack");
        rd_reg(8'h00, d); chk("R7 id after write", d, 8'h31);

        // R2/R4: vector table, write then repeated-START read
        for (int v = 0; v < NV; v++) begin
            wr_reg(VEC[v][15:8], VEC[v][7:0], 1'b0, "R2 ack");
            rd_reg(VEC[v][15:8], d);
            chk("R2 R4 readback", d, VEC[v][7:0]);
        end

        // R3: bursts
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'h0A, 1'b0, ack);
        wr_byte(8'h11, 1'b0, ack); wr_byte(8'h22, 1'b0, ack);
        wr_byte(8'h33, 1'b0, ack); wr_byte(8'h44, 1'b0, ack);
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'h0A, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b0, d); chk("R3 burst0", d, 8'h11);
        rd_byte(1'b0, d); chk("R3 burst1", d, 8'h22);
        rd_byte(1'b1, d); chk("R3 burst2", d, 8'h33);
        wt(Q); chk("R3 released after nack", {7'd0, sda_oe}, 8'd0);
        bus_stop();
        // R4: pointer persists into a plain read
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b1, d); chk("R4 kept pointer", d, 8'h44);
        bus_stop();

        // R1: address mismatch
        bus_start();
        wr_byte({DEV ^ 7'h01, 1'b0}, 1'b0, ack); chk("R1 no ack addr", {7'd0, ack}, 8'd0);
        wr_byte(8'h0A, 1'b0, ack);                chk("R1 no ack ptr", {7'd0, ack}, 8'd0);
        wr_byte(8'h99, 1'b0, ack);                chk("R1 no ack data", {7'd0, ack}, 8'd0);
        bus_stop();
        rd_reg(8'h0A, d); chk("R1 reg untouched", d, 8'h11);

        // R10: out-of-range pointer
        wr_reg(8'h20, 8'h77, 1'b0, "R10 ack");
        rd_reg(8'h20, d); chk("R10 reads zero", d, 8'h00);

        // R5: glitches on both lines
        wr_reg(8'h06, 8'hC3, 1'b1, "R5 ack");
        rd_reg(8'h06, d); chk("R5 glitch write", d, 8'hC3);

        // R9: power-down
        pd_pin = 1'b1; wt(2);
        chk("R9 pin", {7'd0, pd_out}, 8'd1);
        rd_reg(8'h01, d); chk("R9 link in pd", d, 8'hA5);
        pd_pin = 1'b0; wt(2);
        chk("R9 pin low", {7'd0, pd_out}, 8'd0);
        wr_reg(8'h02, 8'h20, 1'b0, "R9 ack");
        chk("R9 bit", {7'd0, pd_out}, 8'd1);
        wr_reg(8'h02, 8'h00, 1'b0, "R9 ack");
        chk("R9 bit clear", {7'd0, pd_out}, 8'd0);

        // R8: self-clearing full reset
        rst_hi = 0;
        wr_reg(8'h02, 8'h10, 1'b0, "R8 ack");
        wt(30);
        chk("R8 pulse length", 8'(rst_hi), 8'd16);
        rd_reg(8'h02, d); chk("R8 bit cleared", d, 8'h00);
        rd_reg(8'h01, d); chk("R8 regs restored", d, 8'h00);
        rd_reg(8'h00, d); chk("R8 id kept", d, 8'h31);

        // R6: line changes only while clock low
        chk("R6 oe changes with scl high", 8'(oe_viol), 8'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule